// File: doc/BRIEF.md
# Interleaved Four-Bank Cache Line Fill Sequencer

This block serves a cache-line miss from a set of one-word-wide memory banks. The banks are interleaved on the low word-address bits, so word j of an aligned line always sits in bank j at the row given by the line address. On an accepted request the sequencer spends one cycle sending the line address. It then starts every bank at once and waits out the fixed access latency, which all banks share. After that it streams the words to the cache fill port, one word per cycle, in ascending order.

A reference mode can be chosen at request time. In that mode the same banks are used one after another, as if the memory were a single one-word-wide array. Each word then costs a full access latency plus a transfer cycle. This makes the cost of a fill without interleaving directly measurable. Each fill ends with a one-cycle done strobe, and the block keeps the measured cycle count of the most recent fill on an output. The bank contents are a fixed pattern loaded at reset. No write path exists.

Top module: `ilv_fill_top`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `busy`, `fill_valid` and `fill_done` are 0 and `fill_cycles` is 0.
- R2: A request is accepted at a rising clock edge where `fill_req` is 1 and `busy` is 0. Cycle 1 is the cycle that follows the acceptance edge. `busy` is 1 from cycle 1 up to and including the cycle that carries the fourth word, and is 0 in the cycle after that.
- R3: With `serial_ref` sampled as 0 at acceptance (interleaved mode), word j (j = 0..3) is presented with `fill_valid` = 1 in cycle 17 + j. The four words therefore appear back to back, and the last word arrives 20 cycles after acceptance.
- R4: `fill_off` carries the word index j of the word being presented, so the values are 0, 1, 2, 3 in that order. `fill_valid` is 0 in every cycle of a fill that does not carry a word.
- R5: Word j of line address B carries the value ((4·B + j) · 0x01010101) XOR 0xA5A50000, taken modulo 2^32 on `fill_data`.
- R6: `fill_done` is 1 for exactly one cycle, the cycle that carries word 3.
- R7: In the cycle after an interleaved fill ends, `fill_cycles` reads 20 (1 address cycle + 15 access cycles + 4 transfer cycles). It holds that value until the next fill ends.
- R8: With `serial_ref` sampled as 1 at acceptance (reference mode), word j is presented in cycle 17 + 16·j, with `fill_valid` low between words. After the fill, `fill_cycles` reads 65.
- R9: A request made while `busy` is 1, including one made in the cycle of word 3, is dropped: it starts no fill. `busy` and `fill_valid` stay 0 once the current fill ends.
- R10: Line address and mode are sampled only at acceptance. Changes on `fill_blk` or `serial_ref` during a fill do not alter that fill's data, timing or cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fill_req | input | 1 | Fill request, taken when `busy` is 0 |
| fill_blk | input | 4 | Aligned line address (bank row) |
| serial_ref | input | 1 | 1 selects the sequential reference mode |
| busy | output | 1 | A fill is in progress |
| fill_valid | output | 1 | A word is presented on `fill_data` |
| fill_off | output | 2 | Word index within the line |
| fill_data | output | 32 | Fill word |
| fill_done | output | 1 | Last word of the fill |
| fill_cycles | output | 7 | Cycle count of the last completed fill |

## Verification
All timing is counted from the acceptance edge. The bench waits on that edge and then samples once per cycle at the falling edge, numbering each cycle n. It then expects a word only at n = 17 + j in interleaved mode, or at n = 17 + 16·j in reference mode, with `busy` and `fill_done` checked at the final word cycle and the cycle after it. `fill_cycles` is read in the cycle after the last word, because it is loaded by the same edge that ends the fill. Random noise on the request, address and mode inputs during a fill checks that nothing outside the acceptance edge shifts these due cycles.

// File: rtl/ilv_fill_pkg.sv
package ilv_fill_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_ADDR   = 2'd1,
        SEQ_ACCESS = 2'd2,
        SEQ_ISSUE  = 2'd3
    } seq_state_e;

    localparam logic [31:0] PAT_MULT = 32'h0101_0101;
    localparam logic [31:0] PAT_MASK = 32'hA5A5_0000;

    // contents of the bank word at a given word address
    function automatic logic [31:0] fill_pattern(input int unsigned word_addr);
        logic [31:0] a;
        a = word_addr;
        return (a * PAT_MULT) ^ PAT_MASK;
    endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank
    import ilv_fill_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int ROW_W   = 4,
    parameter int ACC_LAT = 15,
    parameter int NBANKS  = 4,
    parameter int BANK_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ROW_W-1:0]  row,
    output logic              rdy,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ROW_W;
    localparam int CNT_W = (ACC_LAT > 1) ? $clog2(ACC_LAT) : 1;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rdata_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < DEPTH; r++) begin
                mem[r] <= WORD_W'(fill_pattern(r * NBANKS + BANK_ID));
            end
            rdata_q  <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (start) begin
            rdata_q  <= mem[row];
            cnt_q    <= CNT_W'(ACC_LAT - 1);
            active_q <= 1'b1;
        end else if (active_q && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign rdy   = active_q && (cnt_q == '0);
    assign rdata = rdata_q;

endmodule

// File: rtl/ilv_fill_seq.sv
module ilv_fill_seq
    import ilv_fill_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ROW_W  = 4,
    parameter int NBANKS = 4,
    parameter int IDX_W  = 2,
    parameter int CYC_W  = 7
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req,
    input  logic [ROW_W-1:0]              blk,
    input  logic                          serial,
    input  logic [NBANKS-1:0]             bank_rdy,
    input  logic [NBANKS-1:0][WORD_W-1:0] bank_data,
    output logic [NBANKS-1:0]             bank_start,
    output logic [ROW_W-1:0]              row,
    output logic                          busy,
    output logic                          valid,
    output logic [IDX_W-1:0]              off,
    output logic [WORD_W-1:0]             data,
    output logic                          done,
    output logic [CYC_W-1:0]              cycles,
    output logic                          ser_mode
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBANKS - 1);

    seq_state_e        state_q;
    logic [IDX_W-1:0]  cur_q;
    logic              ser_q;
    logic [ROW_W-1:0]  row_q;
    logic [CYC_W-1:0]  cyc_q;
    logic [CYC_W-1:0]  cycles_q;
    logic              valid_q;
    logic              done_q;
    logic [IDX_W-1:0]  off_q;
    logic [WORD_W-1:0] data_q;

    always_comb begin
        bank_start = '0;
        case (state_q)
            SEQ_ADDR:  bank_start = ser_q ? NBANKS'(1) : '1;
            SEQ_ISSUE: bank_start = NBANKS'(1) << cur_q;
            default:   bank_start = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEQ_IDLE;
            cur_q    <= '0;
            ser_q    <= 1'b0;
            row_q    <= '0;
            cyc_q    <= '0;
            cycles_q <= '0;
            valid_q  <= 1'b0;
            done_q   <= 1'b0;
            off_q    <= '0;
            data_q   <= '0;
        end else begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (req && !done_q) begin
                        state_q <= SEQ_ADDR;
                        ser_q   <= serial;
                        row_q   <= blk;
                        cur_q   <= '0;
                        cyc_q   <= CYC_W'(1);
                    end
                end
                SEQ_ADDR: begin
                    state_q <= SEQ_ACCESS;
                    cyc_q   <= cyc_q + 1'b1;
                end
                SEQ_ACCESS: begin
                    cyc_q <= cyc_q + 1'b1;
                    if (bank_rdy[cur_q]) begin
                        valid_q <= 1'b1;
                        off_q   <= cur_q;
                        data_q  <= bank_data[cur_q];
                        if (cur_q == LAST_IDX) begin
                            done_q   <= 1'b1;
                            cycles_q <= cyc_q + 1'b1;
                            state_q  <= SEQ_IDLE;
                        end else begin
                            cur_q   <= cur_q + 1'b1;
                            state_q <= ser_q ? SEQ_ISSUE : SEQ_ACCESS;
                        end
                    end
                end
                SEQ_ISSUE: begin
                    state_q <= SEQ_ACCESS;
                    cyc_q   <= cyc_q + 1'b1;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign row      = row_q;
    assign busy     = (state_q != SEQ_IDLE) || done_q;
    assign valid    = valid_q;
    assign off      = off_q;
    assign data     = data_q;
    assign done     = done_q;
    assign cycles   = cycles_q;
    assign ser_mode = ser_q;

endmodule

// File: rtl/ilv_fill_top.sv
module ilv_fill_top
    import ilv_fill_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int ROW_W   = 4,
    parameter int NBANKS  = 4,
    parameter int ACC_LAT = 15,
    localparam int IDX_W  = (NBANKS > 1) ? $clog2(NBANKS) : 1,
    localparam int CYC_W  = $clog2(NBANKS * (ACC_LAT + 1) + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_req,
    input  logic [ROW_W-1:0]  fill_blk,
    input  logic              serial_ref,
    output logic              busy,
    output logic              fill_valid,
    output logic [IDX_W-1:0]  fill_off,
    output logic [WORD_W-1:0] fill_data,
    output logic              fill_done,
    output logic [CYC_W-1:0]  fill_cycles
);
    logic [NBANKS-1:0]             bank_start;
    logic [NBANKS-1:0]             bank_rdy;
    logic [NBANKS-1:0][WORD_W-1:0] bank_data;
    logic [ROW_W-1:0]              bank_row;
    logic                          mode_ser;

    for (genvar g = 0; g < NBANKS; g++) begin : g_bank
        ilv_bank #(
            .WORD_W (WORD_W),
            .ROW_W  (ROW_W),
            .ACC_LAT(ACC_LAT),
            .NBANKS (NBANKS),
            .BANK_ID(g)
        ) u_bank (
            .clk  (clk),
            .rst  (rst),
            .start(bank_start[g]),
            .row  (bank_row),
            .rdy  (bank_rdy[g]),
            .rdata(bank_data[g])
        );
    end

    ilv_fill_seq #(
        .WORD_W(WORD_W),
        .ROW_W (ROW_W),
        .NBANKS(NBANKS),
        .IDX_W (IDX_W),
        .CYC_W (CYC_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (fill_req),
        .blk       (fill_blk),
        .serial    (serial_ref),
        .bank_rdy  (bank_rdy),
        .bank_data (bank_data),
        .bank_start(bank_start),
        .row       (bank_row),
        .busy      (busy),
        .valid     (fill_valid),
        .off       (fill_off),
        .data      (fill_data),
        .done      (fill_done),
        .cycles    (fill_cycles),
        .ser_mode  (mode_ser)
    );

endmodule

// File: rtl/ilv_fill_chk.sv
module ilv_fill_chk #(
    parameter int NBANKS = 4,
    parameter int IDX_W  = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             fill_req,
    input logic             busy,
    input logic             fill_valid,
    input logic [IDX_W-1:0] fill_off,
    input logic             fill_done,
    input logic             ser_mode
);
    assert_start_on_req_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(fill_req));

    assert_valid_inside_busy_R4: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> busy);

    assert_done_on_last_R6: assert property (@(posedge clk) disable iff (rst)
        fill_done |-> (fill_valid && (fill_off == IDX_W'(NBANKS - 1))));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        fill_done |=> !fill_done);

    assert_burst_order_R3: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !ser_mode && !fill_done) |=>
            (fill_valid && (fill_off == IDX_W'($past(fill_off) + 1'b1))));

    assert_serial_gap_R8: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && ser_mode) |=> !fill_valid);

endmodule

bind ilv_fill_top ilv_fill_chk #(
    .NBANKS(NBANKS),
    .IDX_W (IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fill_req  (fill_req),
    .busy      (busy),
    .fill_valid(fill_valid),
    .fill_off  (fill_off),
    .fill_done (fill_done),
    .ser_mode  (mode_ser)
);

// File: tb/tb_ilv_fill_top.sv
module tb_ilv_fill_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        fill_req;
    logic [3:0]  fill_blk;
    logic        serial_ref;
    logic        busy;
    logic        fill_valid;
    logic [1:0]  fill_off;
    logic [31:0] fill_data;
    logic        fill_done;
    logic [6:0]  fill_cycles;

    int errors = 0;
    int checks = 0;

    ilv_fill_top dut (
        .clk        (clk),
        .rst        (rst),
        .fill_req   (fill_req),
        .fill_blk   (fill_blk),
        .serial_ref (serial_ref),
        .busy       (busy),
        .fill_valid (fill_valid),
        .fill_off   (fill_off),
        .fill_data  (fill_data),
        .fill_done  (fill_done),
        .fill_cycles(fill_cycles)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] exp_word(input int blk, input int j);
        logic [31:0] a;
        a = 32'(blk * 4 + j);
        return (a * 32'h0101_0101) ^ 32'hA5A5_0000;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one fill from the acceptance edge; noise disturbs inputs mid-fill (R9, R10)
    task automatic run_fill(input int blk, input bit ser, input bit noise);
        int stride;
        int last;
        int stray;
        stride = ser ? 16 : 1;
        last   = 17 + 3 * stride;
        stray  = 0;
        @(negedge clk);
        fill_req   = 1'b1;
        fill_blk   = 4'(blk);
        serial_ref = ser;
        @(posedge clk);
        for (int n = 1; n <= last + 1; n++) begin
            @(negedge clk);
            if (noise && n < last) begin
                fill_req   = 1'($urandom);
                fill_blk   = 4'($urandom);
                serial_ref = 1'($urandom);
            end else begin
                fill_req = 1'b0;
            end
            if (n == 1) check(busy == 1'b1, "R2", "busy in cycle 1", 64'(busy), 64'd1);
            if (n <= last) begin
                if (n >= 17 && ((n - 17) % stride) == 0) begin
                    int j;
                    j = (n - 17) / stride;
                    check(fill_valid && fill_off == 2'(j), ser ? "R8" : "R3",
                          "word slot valid/offset", {fill_valid, 2'b0, fill_off}, 64'(4 + j));
                    check(fill_data == exp_word(blk, j), "R5", "word data",
                          64'(fill_data), 64'(exp_word(blk, j)));
                end else if (fill_valid) begin
                    stray++;
                end
                if (n == last) begin
                    check(fill_done == 1'b1, "R6", "done with word 3", 64'(fill_done), 64'd1);
                    check(busy == 1'b1, "R2", "busy in last word cycle", 64'(busy), 64'd1);
                end else if (fill_done) begin
                    stray++;
                end
            end else begin
                check(busy == 1'b0, "R2", "busy after fill", 64'(busy), 64'd0);
                check(!fill_valid && !fill_done, "R6", "no valid/done after fill",
                      {fill_valid, fill_done}, 64'd0);
                check(fill_cycles == 7'(ser ? 65 : 20), ser ? "R8" : "R7",
                      "cycle count", 64'(fill_cycles), 64'(ser ? 65 : 20));
            end
        end
        check(stray == 0, "R4", "valid/done outside word slots", 64'(stray), 64'd0);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            check(!busy && !fill_valid, "R9", "dropped request started nothing",
                  {busy, fill_valid}, 64'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst        = 1'b1;
        fill_req   = 1'b0;
        fill_blk   = '0;
        serial_ref = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy && !fill_valid && !fill_done && fill_cycles == 0, "R1",
              "outputs in reset", {busy, fill_valid, fill_done, fill_cycles}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !fill_valid && !fill_done && fill_cycles == 0, "R1",
              "outputs after reset", {busy, fill_valid, fill_done, fill_cycles}, 64'd0);

        // directed corners
        run_fill(0, 1'b0, 1'b0);
        run_fill(15, 1'b0, 1'b1);
        run_fill(7, 1'b1, 1'b0);
        run_fill(15, 1'b1, 1'b1);   // R10 noise on address and mode in reference mode
        run_fill(3, 1'b0, 1'b1);

        // constrained random fills
        for (int i = 0; i < 16; i++) begin
            run_fill(int'($urandom_range(15, 0)), 1'($urandom_range(3, 0) == 0),
                     1'($urandom));
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule